// File: doc/BRIEF.md
# Interrupt Post and Clear Register

This block keeps one posted-interrupt flag for each of six peripheral sources: two analog columns, a real-time clock, a SAR ADC and two I2C controllers. A flag is set by a rising edge on the source's hardware event line. The flags drive a downstream priority controller directly. That controller can drop a single flag with a one-cycle acknowledge when it dispatches the interrupt.

Software reaches the flags through a byte-wide register on a simple register bus. A read returns the posted status. The meaning of a write depends on the software-interrupt enable input. When the enable is low, each written zero clears its flag and each written one leaves the flag unchanged. When the enable is high, each written one posts a flag and each written zero leaves the flag unchanged. One register therefore serves both to clear interrupts and to inject them from software.

Top module: `irq_post_clr_reg`

## Requirements
- R1: Flag bit i belongs to source i. Bit 5 is analog column 5, bit 4 is analog column 4, bit 3 is the RTC, bit 2 is the SAR ADC, bit 1 is I2C1 and bit 0 is I2C0. The same index is used on `hw_evt_i`, `ack_i`, `posted_o` and on register bits 5:0.
- R2: When `addr_i` equals `REG_ADDR` (default 0xDD), `rdata_o[5:0]` equals the current flags, combinationally. At any other address `rdata_o` is 0.
- R3: A write with `sw_int_en_i`=0 clears every flag whose written bit is 0.
- R4: A write with `sw_int_en_i`=0 leaves unchanged every flag whose written bit is 1.
- R5: A write with `sw_int_en_i`=1 leaves unchanged every flag whose written bit is 0.
- R6: A write with `sw_int_en_i`=1 sets every flag whose written bit is 1.
- R7: After reset all flags are 0, and `rdata_o` reads 0x00.
- R8: Register bits 7:6 ignore written values and always read 0.
- R9: A flag is set on the clock edge that samples a 0-to-1 transition of its event input. An event input held high does not set the flag again after the flag has been cleared.
- R10: If a hardware set and a clear (a write or an acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R11: A high `ack_i[i]` clears flag i on the next edge and does not affect any other flag. It works whether or not a bus write happens in the same cycle.
- R12: A write takes effect only on an edge where `we_i` is 1 and `addr_i` equals `REG_ADDR`. Any other write leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register bus address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| sw_int_en_i | input | 1 | Selects the write meaning: 0 = clear, 1 = post |
| hw_evt_i | input | 6 | Hardware event lines, one per source |
| ack_i | input | 6 | Dispatch acknowledge, at most one bit high |
| posted_o | output | 6 | Posted flags to the priority controller |

## Verification
The assertions assume that the priority controller raises at most one `ack_i` bit in any cycle. They also assume that `sw_int_en_i` holds steady across the edge at which a write is sampled. The bench changes every input only on the falling clock edge. It drives `ack_i` with a single bit at a time and keeps `sw_int_en_i` fixed for the whole of each write task.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC = 6;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 8;
  // source-to-bit mapping, decoded by the priority controller
  localparam int unsigned SRC_I2C0 = 0;
  localparam int unsigned SRC_I2C1 = 1;
  localparam int unsigned SRC_SAR  = 2;
  localparam int unsigned SRC_RTC  = 3;
  localparam int unsigned SRC_AC4  = 4;
  localparam int unsigned SRC_AC5  = 5;
  typedef enum logic {WR_CLEAR = 1'b0, WR_POST = 1'b1} wr_mode_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end

  // R9
  rise_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hw_set_i,
  input  logic         wr_i,
  input  logic         mode_i,
  input  logic [N-1:0] wbits_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] flag_o
);
  import irq_pkg::*;
  logic [N-1:0] flag_q, sw_set, sw_clr;

  assign sw_set = (wr_i && mode_i == WR_POST)  ?  wbits_i : '0;
  assign sw_clr = (wr_i && mode_i == WR_CLEAR) ? ~wbits_i : '0;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          flag_q[g] <= 1'b0;
      else if (hw_set_i[g] || sw_set[g])    flag_q[g] <= 1'b1; // set wins
      else if (sw_clr[g] || ack_i[g])       flag_q[g] <= 1'b0;
    end
  end
  assign flag_o = flag_q;

  // R11
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_i));
  // R9
  hw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set_i != '0) |=> ((flag_q & $past(hw_set_i)) == $past(hw_set_i)));
  // R6
  sw_post_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && mode_i) |=> ((flag_q & $past(wbits_i)) == $past(wbits_i)));
  // R3
  sw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !mode_i) |=> ((flag_q & ~$past(hw_set_i) & ~$past(wbits_i)) == '0));
  // R11
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i != '0 && !wr_i) |=> ((flag_q & $past(ack_i) & ~$past(hw_set_i)) == '0));
endmodule

// File: rtl/irq_post_clr_reg.sv
module irq_post_clr_reg #(
  parameter int unsigned                  NUM_SRC  = irq_pkg::NUM_SRC,
  parameter int unsigned                  DATA_W   = irq_pkg::DATA_W,
  parameter int unsigned                  ADDR_W   = irq_pkg::ADDR_W,
  parameter logic [irq_pkg::ADDR_W-1:0]   REG_ADDR = 8'hDD
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               sw_int_en_i,
  input  logic [NUM_SRC-1:0] hw_evt_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] posted_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic               hit, wr;
  logic [NUM_SRC-1:0] rise;

  assign hit = (addr_i == REG_ADDR);
  assign wr  = we_i && hit;

  irq_edge_detect #(.N(NUM_SRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (hw_evt_i),
    .rise_o (rise)
  );

  irq_flag_bank #(.N(NUM_SRC)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_set_i (rise),
    .wr_i     (wr),
    .mode_i   (sw_int_en_i),
    .wbits_i  (wdata_i[NUM_SRC-1:0]), // reserved bits dropped
    .ack_i    (ack_i),
    .flag_o   (posted_o)
  );

  assign rdata_o = hit ? {{PAD_W{1'b0}}, posted_o} : '0;

  // R2
  read_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> (rdata_o[NUM_SRC-1:0] == posted_o));
  // R12
  no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr && rise == '0 && ack_i == '0) |=> $stable(posted_o));
endmodule

// File: tb/irq_post_clr_reg_tb.sv
module irq_post_clr_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'hDD;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       swen = 1'b0;
  logic [5:0] hw = '0;
  logic [5:0] ack = '0;
  logic [5:0] posted;
  logic [5:0] exp_f = '0;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  irq_post_clr_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .sw_int_en_i(swen), .hw_evt_i(hw), .ack_i(ack),
    .posted_o(posted)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d, input logic m);
    @(negedge clk); addr = a; wdata = d; swen = m; we = 1'b1;
    tick();
    @(negedge clk); we = 1'b0; addr = 8'hDD;
  endtask

  task automatic pulse_hw(input logic [5:0] v);
    @(negedge clk); hw = v;
    tick();
    @(negedge clk); hw = '0;
  endtask

  task automatic t_reset();
    check("R7 posted", {2'b0, posted}, 8'h00);
    check("R7 rdata", rdata, 8'h00);
  endtask

  task automatic t_hw_map();
    for (int i = 0; i < 6; i++) begin
      pulse_hw(6'(1 << i));
      exp_f[i] = 1'b1;
      check("R1 R9 bit set", {2'b0, posted}, {2'b0, exp_f});
    end
    check("R2 read", rdata, {2'b0, exp_f});
  endtask

  task automatic t_clear_mode();
    bus_wr(8'hDD, 8'h3F, 1'b0);
    check("R4 write-one no effect", {2'b0, posted}, {2'b0, exp_f});
    bus_wr(8'hDD, 8'h2A, 1'b0);
    exp_f = exp_f & 6'h2A;
    check("R3 write-zero clears", {2'b0, posted}, {2'b0, exp_f});
  endtask

  task automatic t_post_mode();
    bus_wr(8'hDD, 8'h00, 1'b1);
    check("R5 write-zero no effect", {2'b0, posted}, {2'b0, exp_f});
    bus_wr(8'hDD, 8'h05, 1'b1);
    exp_f = exp_f | 6'h05;
    check("R6 write-one posts", {2'b0, posted}, {2'b0, exp_f});
  endtask

  task automatic t_reserved();
    bus_wr(8'hDD, 8'h00, 1'b0);
    exp_f = '0;
    bus_wr(8'hDD, 8'hC0, 1'b1);
    check("R8 reserved read", rdata, 8'h00);
    bus_wr(8'hDD, 8'hFF, 1'b1);
    exp_f = 6'h3F;
    check("R8 reserved masked", rdata, 8'h3F);
  endtask

  task automatic t_addr();
    bus_wr(8'hDC, 8'h00, 1'b0);
    check("R12 other address", {2'b0, posted}, {2'b0, exp_f});
    @(negedge clk); addr = 8'hDD; wdata = 8'h00; swen = 1'b0; we = 1'b0;
    tick();
    check("R12 we low", {2'b0, posted}, {2'b0, exp_f});
    @(negedge clk); addr = 8'h10; #1;
    check("R2 other address reads 0", rdata, 8'h00);
    @(negedge clk); addr = 8'hDD;
  endtask

  task automatic t_level_held();
    bus_wr(8'hDD, 8'h00, 1'b0);
    exp_f = '0;
    @(negedge clk); hw = 6'h10;
    tick();
    exp_f[4] = 1'b1;
    check("R9 rise sets", {2'b0, posted}, {2'b0, exp_f});
    bus_wr(8'hDD, 8'h00, 1'b0);
    exp_f = '0;
    tick(); tick();
    check("R9 held level no reset", {2'b0, posted}, 8'h00);
    @(negedge clk); hw = '0;
  endtask

  task automatic t_collision();
    @(negedge clk); hw = 6'h08; addr = 8'hDD; wdata = 8'h00; swen = 1'b0; we = 1'b1;
    tick();
    @(negedge clk); we = 1'b0; hw = '0;
    exp_f = 6'h08;
    check("R10 set beats write clear", {2'b0, posted}, {2'b0, exp_f});
    @(negedge clk); hw = 6'h08; ack = 6'h08;
    tick();
    @(negedge clk); hw = '0; ack = '0;
    check("R10 set beats ack", {2'b0, posted}, {2'b0, exp_f});
  endtask

  task automatic t_ack();
    bus_wr(8'hDD, 8'h3F, 1'b1);
    exp_f = 6'h3F;
    @(negedge clk); ack = 6'h02;
    tick();
    @(negedge clk); ack = '0;
    exp_f[1] = 1'b0;
    check("R11 ack single flag", {2'b0, posted}, {2'b0, exp_f});
    @(negedge clk); bus_wr(8'hDD, 8'h00, 1'b0);
    exp_f = '0;
    @(negedge clk); addr = 8'hDD; wdata = 8'h01; swen = 1'b1; we = 1'b1; ack = 6'h20;
    bus_wr(8'hDD, 8'h00, 1'b1);
    exp_f = 6'h01;
    ack = '0;
    check("R11 ack with write", {2'b0, posted}, {2'b0, exp_f});
  endtask

  initial begin
    fork
      begin
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        tick();
        t_reset();
        t_hw_map();
        t_clear_mode();
        t_post_mode();
        t_reserved();
        t_addr();
        t_level_held();
        t_collision();
        t_ack();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule